// File: doc/BRIEF.md
# Dual-Rail Set-Only Register Word with Scan Chain

This block holds a word of dual-rail values for a sleep-gated asynchronous pipeline stage. Each bit has two storage cells, one for the false rail and one for the true rail. In functional mode a sleep control forces every rail low, which presents the spacer value NULL. Once sleep is released, a rail goes high as soon as its data input is seen high. It then stays high until the next sleep, so a data input falling never clears a rail.

For test, the same cells are strung into one scan chain. Two non-overlapping shift phases move data along the chain in the manner of a master/slave level-sensitive scan element. A capture strobe loads the outputs of the logic in front of the register into every cell at once. The design samples all controls on a single clock, with synchronous active-high reset. A shift phase or the capture strobe that is high at a rising edge counts as active for that edge.

Top module: `dr_scan_reg`

## Requirements
- R1: Bit i is read as logic 1 when `q_rail1[i]`=1 and `q_rail0[i]`=0. It is read as logic 0 when `q_rail0[i]`=1 and `q_rail1[i]`=0. Both rails low is NULL.
- R2: Synchronous reset clears every rail and `ctl_err` to 0 at the next rising edge.
- R3: With `mode_test`=0 and `sleep`=1, every rail is 0 after the next edge and stays 0 while sleep is held, even if data inputs are high.
- R4: With `mode_test`=0 and `sleep`=0, a rail whose data input is 1 at an edge reads 1 after that edge.
- R5: A rail that is set stays 1 after its data input returns to 0. Only sleep in functional mode, or reset, clears it.
- R6: With `mode_test`=1, `shift_a` loads each cell's hidden master stage from its scan input, and `shift_b` copies the master stage to the cell output. The chain runs `scan_in` → bit0 false rail → bit0 true rail → bit1 false rail → … → last bit true rail, which drives `scan_out`. One `shift_a` edge followed by one `shift_b` edge moves the chain one place.
- R7: With `mode_test`=1, `capture` high and both shift phases low, each cell takes its data input and shows it on its output after the edge.
- R8: In test mode, `capture` together with either shift phase, or both shift phases together, raises `ctl_err` after that edge and leaves all cells unchanged. `ctl_err` is 0 after any edge without such a conflict.
- R9: `sleep` has no effect in test mode. `shift_a`, `shift_b` and `capture` have no effect in functional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_test | input | 1 | 0 = functional, 1 = scan test |
| sleep | input | 1 | Forces NULL in functional mode |
| shift_a | input | 1 | First shift phase (master load) |
| shift_b | input | 1 | Second shift phase (slave load) |
| capture | input | 1 | Parallel load from data inputs in test mode |
| d_rail0 | input | NBITS | False-rail data inputs |
| d_rail1 | input | NBITS | True-rail data inputs |
| scan_in | input | 1 | Serial input to the first cell |
| q_rail0 | output | NBITS | False-rail outputs |
| q_rail1 | output | NBITS | True-rail outputs |
| scan_out | output | 1 | Output of the last cell in the chain |
| ctl_err | output | 1 | Test-control conflict seen at the last edge |

## Verification
Every result appears one rising edge after the edge that samples its stimulus. This holds for latching, sleep clearing, capture, the master and slave steps of a shift, and the conflict flag. A full chain move therefore costs two edges. The bench applies inputs at a falling edge and computes the expected rails and flag at the following rising edge. It queues them, and a monitor compares the queued item at the next falling edge, when the registered outputs have settled.

// File: rtl/dr_scan_pkg.sv
package dr_scan_pkg;
  // Per-edge action decoded once for all cells
  typedef enum logic [2:0] {
    OP_SLEEP   = 3'd0,
    OP_RUN     = 3'd1,
    OP_CAPTURE = 3'd2,
    OP_SHIFT   = 3'd3,
    OP_HOLD    = 3'd4
  } cell_op_e;
endpackage

// File: rtl/dr_scan_ctrl.sv
module dr_scan_ctrl
  import dr_scan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mode_test,
  input  logic     sleep,
  input  logic     shift_a,
  input  logic     shift_b,
  input  logic     capture,
  output cell_op_e op,
  output logic     ctl_err
);
  logic conflict;

  assign conflict = (capture && (shift_a || shift_b)) || (shift_a && shift_b);

  always_comb begin
    if (!mode_test)    op = sleep ? OP_SLEEP : OP_RUN;
    else if (conflict) op = OP_HOLD;
    else if (capture)  op = OP_CAPTURE;
    else               op = OP_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_err <= 1'b0;
    else     ctl_err <= mode_test && conflict;
  end

  // R8: functional mode never reports a test-control conflict
  assert_err_quiet_normal_R8: assert property (@(posedge clk) disable iff (rst)
    !mode_test |=> !ctl_err);
endmodule

// File: rtl/dr_scan_cell.sv
module dr_scan_cell
  import dr_scan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cell_op_e op,
  input  logic     shift_a,
  input  logic     shift_b,
  input  logic     din,
  input  logic     sin,
  output logic     dout
);
  logic mst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst  <= 1'b0;
      dout <= 1'b0;
    end else begin
      case (op)
        OP_SLEEP: begin
          mst  <= 1'b0;
          dout <= 1'b0;
        end
        OP_RUN: begin
          if (din) dout <= 1'b1;
        end
        OP_CAPTURE: begin
          mst  <= din;
          dout <= din;
        end
        OP_SHIFT: begin
          if (shift_a) mst  <= sin;
          if (shift_b) dout <= mst;
        end
        default: ;
      endcase
    end
  end

  // R6: the second shift phase exposes what the master stage held
  assert_master_xfer_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT && shift_b) |=> (dout == $past(mst)));

  // R7: capture presents the data input on the output
  assert_capture_din_R7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CAPTURE) |=> (dout == $past(din)));
endmodule

// File: rtl/dr_scan_reg.sv
module dr_scan_reg
  import dr_scan_pkg::*;
#(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_test,
  input  logic             sleep,
  input  logic             shift_a,
  input  logic             shift_b,
  input  logic             capture,
  input  logic [NBITS-1:0] d_rail0,
  input  logic [NBITS-1:0] d_rail1,
  input  logic             scan_in,
  output logic [NBITS-1:0] q_rail0,
  output logic [NBITS-1:0] q_rail1,
  output logic             scan_out,
  output logic             ctl_err
);
  localparam int NCELLS = 2 * NBITS;

  cell_op_e          op;
  logic [NCELLS-1:0] din_v;
  logic [NCELLS-1:0] dout_v;
  logic [NCELLS-1:0] sin_v;

  dr_scan_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_test (mode_test),
    .sleep     (sleep),
    .shift_a   (shift_a),
    .shift_b   (shift_b),
    .capture   (capture),
    .op        (op),
    .ctl_err   (ctl_err)
  );

  // Chain order: scan_in, then per bit false rail then true rail
  assign sin_v = {dout_v[NCELLS-2:0], scan_in};

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign din_v[2*i]   = d_rail0[i];
    assign din_v[2*i+1] = d_rail1[i];
    assign q_rail0[i]   = dout_v[2*i];
    assign q_rail1[i]   = dout_v[2*i+1];
  end

  for (genvar k = 0; k < NCELLS; k++) begin : g_cell
    dr_scan_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .shift_a (shift_a),
      .shift_b (shift_b),
      .din     (din_v[k]),
      .sin     (sin_v[k]),
      .dout    (dout_v[k])
    );
  end

  assign scan_out = dout_v[NCELLS-1];

  // R3: sleep in functional mode yields NULL everywhere
  assert_sleep_null_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode_test && sleep) |=> (q_rail0 == '0 && q_rail1 == '0));

  // R4: a high data input sets its rail
  assert_data_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (!mode_test && !sleep) |=>
      (((q_rail0 & $past(d_rail0)) == $past(d_rail0)) &&
       ((q_rail1 & $past(d_rail1)) == $past(d_rail1))));

  // R5: a set rail is never cleared by its input while awake
  assert_set_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!mode_test && !sleep) |=>
      (((q_rail0 & $past(q_rail0)) == $past(q_rail0)) &&
       ((q_rail1 & $past(q_rail1)) == $past(q_rail1))));

  // R8: conflicting test controls flag an error and freeze the cells
  assert_conflict_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_test && ((capture && (shift_a || shift_b)) || (shift_a && shift_b)))
      |=> (ctl_err && $stable(q_rail0) && $stable(q_rail1)));

  // R9: in test mode, without shift_b or capture, outputs do not move (sleep ignored)
  assert_test_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_test && !shift_b && !capture) |=> ($stable(q_rail0) && $stable(q_rail1)));
endmodule

// File: tb/sim_dr_scan_reg.sv
`timescale 1ns/1ps
module sim_dr_scan_reg;
  localparam int NB = 4;
  localparam int NC = 2 * NB;

  typedef struct {
    string         tag;
    logic [NB-1:0] e0;
    logic [NB-1:0] e1;
    logic          eso;
    logic          eerr;
  } exp_t;

  logic clk = 1'b0;
  logic rst, mode_test, sleep, shift_a, shift_b, capture, scan_in;
  logic [NB-1:0] d_rail0, d_rail1, q_rail0, q_rail1;
  logic scan_out, ctl_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t sb[$];

  logic [NC-1:0] mdl_s = '0;
  logic [NC-1:0] mdl_m = '0;

  always #2.5 clk = ~clk;

  dr_scan_reg #(.NBITS(NB)) u0 (
    .clk(clk), .rst(rst), .mode_test(mode_test), .sleep(sleep),
    .shift_a(shift_a), .shift_b(shift_b), .capture(capture),
    .d_rail0(d_rail0), .d_rail1(d_rail1), .scan_in(scan_in),
    .q_rail0(q_rail0), .q_rail1(q_rail1), .scan_out(scan_out), .ctl_err(ctl_err)
  );

  // Driver: one edge of stimulus, expected outputs pushed to the scoreboard
  task automatic tick(input string tag);
    logic [NC-1:0] din_v, nm, ns;
    logic err;
    exp_t it;
    @(posedge clk);
    for (int i = 0; i < NB; i++) begin
      din_v[2*i]   = d_rail0[i];
      din_v[2*i+1] = d_rail1[i];
    end
    nm = mdl_m; ns = mdl_s;
    err = mode_test && ((capture && (shift_a || shift_b)) || (shift_a && shift_b));
    if (rst) begin
      nm = '0; ns = '0; err = 1'b0;
    end else if (!mode_test) begin
      if (sleep) begin nm = '0; ns = '0; end
      else ns = mdl_s | din_v;
    end else if (!err) begin
      if (capture) begin nm = din_v; ns = din_v; end
      else begin
        if (shift_a) nm = {mdl_s[NC-2:0], scan_in};
        if (shift_b) ns = mdl_m;
      end
    end
    mdl_m = nm; mdl_s = ns;
    it.tag = tag;
    for (int i = 0; i < NB; i++) begin
      it.e0[i] = ns[2*i];
      it.e1[i] = ns[2*i+1];
    end
    it.eso = ns[NC-1];
    it.eerr = err;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare away from the rising edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (q_rail0 !== it.e0 || q_rail1 !== it.e1 || scan_out !== it.eso || ctl_err !== it.eerr) begin
        failures++;
        $display("FAIL %s actual q0=%b q1=%b so=%b err=%b expected q0=%b q1=%b so=%b err=%b",
                 it.tag, q_rail0, q_rail1, scan_out, ctl_err, it.e0, it.e1, it.eso, it.eerr);
      end
    end
  end

  task automatic idle_ctl();
    shift_a = 0; shift_b = 0; capture = 0;
  endtask

  task automatic shift_pair(input logic bit_in, input string tag);
    scan_in = bit_in;
    shift_a = 1; tick(tag);
    shift_a = 0; shift_b = 1; tick(tag);
    shift_b = 0;
  endtask

  initial begin
    logic [NC-1:0] pat;
    rst = 1; mode_test = 0; sleep = 0; scan_in = 0;
    d_rail0 = '0; d_rail1 = '0; idle_ctl();
    @(negedge clk);
    tick("R2 reset"); tick("R2 reset");
    rst = 0;
    // R4: set rails from data
    d_rail0 = 4'b0101; d_rail1 = 4'b1000; tick("R4 set");
    // R5: inputs fall, rails hold
    d_rail0 = '0; d_rail1 = '0; tick("R5 hold"); tick("R5 hold");
    // R1: bit 1 logic 1 (true rail only), bit 0 logic 0 (false rail only)
    d_rail1 = 4'b0010; tick("R1 encoding"); d_rail1 = '0;
    // R9: test controls ignored in functional mode
    shift_a = 1; tick("R9 normal shift_a");
    shift_a = 0; shift_b = 1; tick("R9 normal shift_b");
    shift_b = 0; capture = 1; tick("R9 normal capture"); capture = 0;
    // R3: sleep clears and holds NULL even with data high
    sleep = 1; d_rail0 = '1; d_rail1 = '1; tick("R3 sleep"); tick("R3 sleep held");
    sleep = 0; d_rail0 = '0; d_rail1 = '0; tick("R3 released");
    // R6: shift a known pattern through all cells
    mode_test = 1;
    pat = 8'b1011_0010;
    for (int j = 0; j < NC; j++) shift_pair(pat[j], "R6 shift in");
    // R9: sleep ignored in test mode
    sleep = 1; tick("R9 test sleep"); sleep = 0;
    // R6: lone shift_a alone leaves outputs unchanged
    scan_in = 1; shift_a = 1; tick("R6 master only"); shift_a = 0;
    shift_b = 1; tick("R6 slave step"); shift_b = 0;
    // R7: capture
    d_rail0 = 4'b1100; d_rail1 = 4'b0011; capture = 1; tick("R7 capture");
    capture = 0; d_rail0 = '0; d_rail1 = '0; tick("R7 after capture");
    for (int j = 0; j < NC; j++) shift_pair(1'b0, "R6 shift out");
    // R8: conflicts
    d_rail0 = 4'b1111; capture = 1;
    tick("R7 capture again"); tick("R7 capture again");
    d_rail0 = '0; shift_a = 1; tick("R8 capture+shift_a");
    capture = 0; shift_b = 1; tick("R8 shift_a+shift_b");
    shift_a = 0; capture = 1; tick("R8 capture+shift_b");
    idle_ctl(); tick("R8 flag clears");
    mode_test = 0; tick("R8 normal");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2-R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule